// File: doc/BRIEF.md
# Capture-Compare General-Purpose Timer

This block is a 32-bit up-counting timer for use as a peripheral behind a simple register-mapped slave port. The counter advances on a prescaled tick whose period is a power of two clock cycles, selected between 1 and 256. Software can start and stop it. When it rolls over it either wraps to zero or restarts from a programmed reload value.

A match register drives a registered PWM or trigger output. A synchronized external event input snapshots the running count into a capture register on a chosen edge. Three independent sources raise sticky interrupt flags: rollover, match and capture. Each flag is cleared by writing a one to it, and an enable mask decides which flags reach the single interrupt line.

All registers remain accessible while the counter runs. A write to the count register during counting is deferred to the next tick, so the counter stays coherent and no false match event is raised. Accesses are whole words or half words chosen by the byte-enable lanes.

Top module: `capCmpTimer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped, `pwmOut` is low and `irqOut` is low.
- R2: Configuration register (offset 0x00) bit 0 starts the counter. While running, the count rises by one on each tick, and a tick occurs every 2^n clocks, with n taken from bits [7:4] and values above 8 treated as 8. While stopped, the count holds its value.
- R3: A tick at count 0xFFFFFFFF is a rollover. It loads zero, or the reload register (offset 0x08) when configuration bit 1 is set, and it sets status bit 0.
- R4: With configuration bit 2 set, a tick that makes the count equal to the match register (offset 0x0C) sets status bit 1.
- R5: When configuration bit 3 is 0, `pwmOut` goes high on rollover and low on a match, and rollover wins if both occur on one tick. When bit 3 is 1, `pwmOut` toggles on each match and ignores rollover.
- R6: Configuration bits [9:8] select the capture edge of `capIn`: 00 off, 01 rising, 10 falling, 11 both. The input passes through two synchronizing flops. A selected edge copies the count into the capture register (offset 0x10, read-only) and sets status bit 2. An edge that is not selected changes neither.
- R7: Status (offset 0x14) bits stay set until a one is written to them. Writing a one clears only that bit. A new event in the same cycle as a clear leaves its bit set.
- R8: `irqOut` is high exactly when some status bit is set and its bit in the enable register (offset 0x18) is also set.
- R9: A count write (offset 0x04) while running does not change the count until the next tick, which loads the written value and raises no match event. While stopped, a count write takes effect at once.
- R10: Addresses are word-aligned (bits [1:0] zero). Writes are accepted only with byte enables 1111, 0011 (low half) or 1100 (high half), and any other pattern is ignored. Reads return the full word, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Byte address |
| busBe | input | 4 | Byte-lane enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| capIn | input | 1 | External capture event, asynchronous |
| pwmOut | output | 1 | Registered PWM / trigger output |
| irqOut | output | 1 | Interrupt request |

## Verification
A fault in the prescaler or the step logic changes the count read back after a known number of cycles. Each tick test therefore stops the counter on an exact edge and compares the value. A wrong rollover or match decision shows up one cycle later as a wrong status bit, and within one PWM period as a wrong high-time ratio on `pwmOut`. Capture faults show three cycles after the input edge as a wrong capture value or flag. A misrouted pending write appears at the next tick as a wrong count or a spurious match flag.

// File: rtl/tmrPkg.sv
package tmrPkg;
  localparam int CNT_W   = 32;
  localparam int PRESC_W = 8;
  localparam int SEL_W   = 4;
  localparam int ADDR_W  = 10;
  localparam int BE_W    = CNT_W / 8;
  localparam int NUM_IRQ = 3;

  // bit 0 run, 1 autoReload, 2 cmpEn, 3 pwmToggle, [7:4] prescSel, [9:8] capEdge
  typedef struct packed {
    logic [1:0]       capEdge;
    logic [SEL_W-1:0] prescSel;
    logic             pwmToggle;
    logic             cmpEn;
    logic             autoReload;
    logic             run;
  } tmrCfg_t;

  localparam int CFG_W = $bits(tmrCfg_t);

  typedef struct packed {
    logic             cntWr;
    logic [CNT_W-1:0] cntData;
  } tmrStrb_t;

  // bit 0 rollover, bit 1 match, bit 2 capture (matches status layout)
  typedef struct packed {
    logic cap;
    logic match;
    logic ovf;
  } tmrEvt_t;
endpackage

// File: rtl/tmrDatapath.sv
module tmrDatapath import tmrPkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCfg_t          cfg,
  input  tmrStrb_t         strb,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] matchVal,
  input  logic             capIn,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capVal,
  output tmrEvt_t          evt,
  output logic             pwm
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PRESC_W-1:0] prescCnt;
  logic [PRESC_W-1:0] prescMask;
  logic [SEL_W-1:0]   shiftEff;
  logic               tick;
  logic               pendLoad;
  logic [CNT_W-1:0]   pendVal;
  logic [CNT_W-1:0]   nextCnt;
  logic               atMax;
  logic               capSync1, capSync2, capPrev;
  logic               capRise, capFall;

  // prescaler: tick when the low n bits of the free counter are all ones
  always_comb shiftEff = (cfg.prescSel > SEL_W'(PRESC_W)) ? SEL_W'(PRESC_W) : cfg.prescSel;

  generate
    for (genvar i = 0; i < PRESC_W; i++) begin : g_mask
      assign prescMask[i] = (SEL_W'(i) < shiftEff);
    end
  endgenerate

  assign tick = cfg.run && ((prescCnt & prescMask) == prescMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        prescCnt <= '0;
    else if (!cfg.run) prescCnt <= '0;
    else               prescCnt <= prescCnt + 1'b1;
  end

  // counter next value and events
  assign atMax = (count == CNT_MAX);

  always_comb begin
    if (atMax) nextCnt = cfg.autoReload ? reloadVal : '0;
    else       nextCnt = count + 1'b1;
  end

  assign evt.ovf   = tick && !pendLoad && atMax;
  assign evt.match = tick && !pendLoad && cfg.cmpEn && (nextCnt == matchVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       count <= '0;
    else if (strb.cntWr && !cfg.run) count <= strb.cntData;
    else if (tick)                   count <= pendLoad ? pendVal : nextCnt;
  end

  // deferred software load while running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendLoad <= 1'b0;
      pendVal  <= '0;
    end else if (strb.cntWr) begin
      pendLoad <= cfg.run;
      pendVal  <= strb.cntData;
    end else if (tick) begin
      pendLoad <= 1'b0;
    end
  end

  // capture path: two-flop synchronizer then edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSync1 <= 1'b0;
      capSync2 <= 1'b0;
      capPrev  <= 1'b0;
    end else begin
      capSync1 <= capIn;
      capSync2 <= capSync1;
      capPrev  <= capSync2;
    end
  end

  assign capRise = capSync2 && !capPrev;
  assign capFall = !capSync2 && capPrev;
  assign evt.cap = (capRise && cfg.capEdge[0]) || (capFall && cfg.capEdge[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        capVal <= '0;
    else if (evt.cap) capVal <= count;
  end

  // registered PWM output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            pwm <= 1'b0;
    else if (evt.ovf && !cfg.pwmToggle)   pwm <= 1'b1;
    else if (evt.match)                   pwm <= cfg.pwmToggle ? ~pwm : 1'b0;
  end

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.run && !strb.cntWr) |=> $stable(count));

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !pendLoad && !atMax) |=> (count == $past(count) + CNT_W'(1)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    evt.ovf |=> (count == ($past(cfg.autoReload) ? $past(reloadVal) : '0)));

  p_match_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    evt.match |=> (count == $past(matchVal)));

  p_pwm_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwm) |-> $past(evt.ovf || (evt.match && cfg.pwmToggle)));

  p_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    evt.cap |=> (capVal == $past(count)));

  p_pending_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tick && pendLoad && !strb.cntWr) |=> (count == $past(pendVal) && !pendLoad));
endmodule

// File: rtl/tmrCtrl.sv
module tmrCtrl import tmrPkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BE_W-1:0]   busBe,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  capVal,
  input  tmrEvt_t           evt,
  output tmrCfg_t           cfg,
  output tmrStrb_t          strb,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [CNT_W-1:0]  matchVal,
  output logic              irqOut
);
  localparam int WORD_LSB = $clog2(BE_W);
  localparam int IDX_W    = ADDR_W - WORD_LSB;
  localparam int HALF_W   = CNT_W / 2;
  localparam logic [IDX_W-1:0] REG_CFG    = IDX_W'(0);
  localparam logic [IDX_W-1:0] REG_COUNT  = IDX_W'(1);
  localparam logic [IDX_W-1:0] REG_RELOAD = IDX_W'(2);
  localparam logic [IDX_W-1:0] REG_MATCH  = IDX_W'(3);
  localparam logic [IDX_W-1:0] REG_CAPT   = IDX_W'(4);
  localparam logic [IDX_W-1:0] REG_STATUS = IDX_W'(5);
  localparam logic [IDX_W-1:0] REG_ENABLE = IDX_W'(6);
  localparam logic [BE_W-1:0]  BE_LOW  = BE_W'((1 << (BE_W/2)) - 1);
  localparam logic [BE_W-1:0]  BE_HIGH = ~BE_LOW;

  logic [CFG_W-1:0]   cfgReg;
  logic [NUM_IRQ-1:0] statusReg, enableReg, evtBits, clrBits;
  logic [IDX_W-1:0]   idx;
  logic               aligned, beOk, wrEn, stWr;
  logic [CNT_W-1:0]   wMask;

  function automatic logic [CNT_W-1:0] mergeHalf(input logic [CNT_W-1:0] oldV,
                                                 input logic [CNT_W-1:0] newV,
                                                 input logic [CNT_W-1:0] mask);
    return (oldV & ~mask) | (newV & mask);
  endfunction

  assign idx     = busAddr[ADDR_W-1:WORD_LSB];
  assign aligned = (busAddr[WORD_LSB-1:0] == '0);
  assign beOk    = (busBe == '1) || (busBe == BE_LOW) || (busBe == BE_HIGH);
  assign wrEn    = busSel && busWr && aligned && beOk;
  assign wMask   = {{HALF_W{busBe[BE_W-1]}}, {HALF_W{busBe[0]}}};
  assign stWr    = wrEn && (idx == REG_STATUS);
  assign evtBits = evt;
  assign clrBits = stWr ? (busWdata[NUM_IRQ-1:0] & wMask[NUM_IRQ-1:0]) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg    <= '0;
      reloadVal <= '0;
      matchVal  <= '0;
      enableReg <= '0;
    end else if (wrEn) begin
      case (idx)
        REG_CFG:    cfgReg    <= CFG_W'(mergeHalf(CNT_W'(cfgReg), busWdata, wMask));
        REG_RELOAD: reloadVal <= mergeHalf(reloadVal, busWdata, wMask);
        REG_MATCH:  matchVal  <= mergeHalf(matchVal, busWdata, wMask);
        REG_ENABLE: enableReg <= NUM_IRQ'(mergeHalf(CNT_W'(enableReg), busWdata, wMask));
        default: ;
      endcase
    end
  end

  // sticky status, events win over write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= (statusReg & ~clrBits) | evtBits;
  end

  assign cfg          = tmrCfg_t'(cfgReg);
  assign strb.cntWr   = wrEn && (idx == REG_COUNT);
  assign strb.cntData = mergeHalf(count, busWdata, wMask);
  assign irqOut       = |(statusReg & enableReg);

  always_comb begin
    busRdata = '0;
    if (aligned) begin
      case (idx)
        REG_CFG:    busRdata = CNT_W'(cfgReg);
        REG_COUNT:  busRdata = count;
        REG_RELOAD: busRdata = reloadVal;
        REG_MATCH:  busRdata = matchVal;
        REG_CAPT:   busRdata = capVal;
        REG_STATUS: busRdata = CNT_W'(statusReg);
        REG_ENABLE: busRdata = CNT_W'(enableReg);
        default:    busRdata = '0;
      endcase
    end
  end

  p_event_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    (evtBits != '0) |=> ((statusReg & $past(evtBits)) == $past(evtBits)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stWr |=> ((statusReg & $past(statusReg)) == $past(statusReg)));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enableReg == '0) |-> !irqOut);

  p_narrow_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && !beOk) |=> ($stable(cfgReg) && $stable(reloadVal) &&
                                    $stable(matchVal) && $stable(enableReg)));
endmodule

// File: rtl/capCmpTimer.sv
module capCmpTimer import tmrPkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BE_W-1:0]   busBe,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  input  logic              capIn,
  output logic              pwmOut,
  output logic              irqOut
);
  tmrCfg_t          cfg;
  tmrStrb_t         strb;
  tmrEvt_t          evt;
  logic [CNT_W-1:0] count, capVal, reloadVal, matchVal;

  tmrCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata),
    .count(count), .capVal(capVal), .evt(evt),
    .cfg(cfg), .strb(strb), .reloadVal(reloadVal), .matchVal(matchVal),
    .irqOut(irqOut)
  );

  tmrDatapath u_dp (
    .clk(clk), .rstN(rstN),
    .cfg(cfg), .strb(strb), .reloadVal(reloadVal), .matchVal(matchVal),
    .capIn(capIn), .count(count), .capVal(capVal), .evt(evt), .pwm(pwmOut)
  );
endmodule

// File: tb/sim_capCmpTimer.sv
module sim_capCmpTimer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        capIn = 1'b0;
  logic        pwmOut, irqOut;
  int          nChecks = 0, nFail = 0;

  localparam logic [9:0] A_CFG = 10'h00, A_CNT = 10'h04, A_RLD = 10'h08, A_MAT = 10'h0C,
                         A_CAP = 10'h10, A_STS = 10'h14, A_ENA = 10'h18;

  capCmpTimer u0 (.clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
                  .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata),
                  .capIn(capIn), .pwmOut(pwmOut), .irqOut(irqOut));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d; busBe = be;
    @(posedge clk);
    #1 busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(A_CFG, v); chk("R1 cfg", v, 0);
    rd(A_CNT, v); chk("R1 count", v, 0);
    rd(A_CAP, v); chk("R1 capture", v, 0);
    rd(A_STS, v); chk("R1 status", v, 0);
    chk("R1 pwm", pwmOut, 0);
    chk("R1 irq", irqOut, 0);
  endtask

  task automatic testHoldAndPrescale();
    logic [31:0] v;
    wr(A_CNT, 32'd5);
    repeat (20) @(posedge clk);
    rd(A_CNT, v); chk("R2 hold while stopped", v, 5);
    wr(A_CNT, 0);
    wr(A_CFG, 32'h21);               // run, n=2
    repeat (40) @(posedge clk);
    wr(A_CFG, 0);
    rd(A_CNT, v); chk("R2 divide by 4", v, 10);
    wr(A_CNT, 0);
    wr(A_CFG, 32'hC1);               // run, n=12 acts as 8
    repeat (512) @(posedge clk);
    wr(A_CFG, 0);
    rd(A_CNT, v); chk("R2 clamp to 256", v, 2);
  endtask

  task automatic testOverflow();
    logic [31:0] v;
    wr(A_CNT, 32'hFFFF_FFFD);
    wr(A_CFG, 32'h1);
    repeat (5) @(posedge clk);
    wr(A_CFG, 0);
    rd(A_CNT, v); chk("R3 wrap to zero", v, 3);
    rd(A_STS, v); chk("R3 rollover flag", v, 1);
    wr(A_RLD, 32'h1000);
    wr(A_CNT, 32'hFFFF_FFFD);
    wr(A_CFG, 32'h3);
    repeat (5) @(posedge clk);
    wr(A_CFG, 0);
    rd(A_CNT, v); chk("R3 auto reload", v, 32'h1003);
  endtask

  task automatic testCompareIrq();
    logic [31:0] v;
    wr(A_CNT, 0);
    wr(A_MAT, 5);
    wr(A_CFG, 32'h5);
    repeat (6) @(posedge clk);
    wr(A_CFG, 0);
    rd(A_CNT, v); chk("R4 count at stop", v, 7);
    rd(A_STS, v); chk("R4 match flag", v, 3);
    chk("R8 irq masked", irqOut, 0);
    wr(A_ENA, 32'h4);
    chk("R8 other source enabled", irqOut, 0);
    wr(A_ENA, 32'h2);
    chk("R8 irq asserted", irqOut, 1);
    wr(A_STS, 32'h2);
    rd(A_STS, v); chk("R7 clear one bit only", v, 1);
    chk("R8 irq after clear", irqOut, 0);
    wr(A_STS, 32'h1);
    rd(A_STS, v); chk("R7 clear remaining", v, 0);
    wr(A_ENA, 0);
  endtask

  task automatic testPendingWrite();
    logic [31:0] v;
    wr(A_CNT, 0);
    wr(A_MAT, 32'h80);
    wr(A_CFG, 32'h35);               // run, cmpEn, n=3
    repeat (3) @(posedge clk);
    wr(A_CNT, 32'h80);
    rd(A_CNT, v); chk("R9 not applied before tick", v, 0);
    repeat (12) @(posedge clk);
    wr(A_CFG, 0);
    rd(A_CNT, v); chk("R9 applied at tick", v, 32'h81);
    rd(A_STS, v); chk("R9 no match on load", v, 0);
  endtask

  task automatic testPwm();
    int hi;
    wr(A_RLD, 32'hFFFF_FFF0);
    wr(A_MAT, 32'hFFFF_FFF4);
    wr(A_CNT, 32'hFFFF_FFF0);
    wr(A_CFG, 32'h7);                // run, reload, cmpEn, clear mode
    repeat (32) @(posedge clk);
    hi = 0;
    for (int i = 0; i < 32; i++) begin @(negedge clk); if (pwmOut) hi++; end
    chk("R5 clear mode duty", hi, 8);
    wr(A_CFG, 32'hF);                // toggle mode
    repeat (32) @(posedge clk);
    hi = 0;
    for (int i = 0; i < 32; i++) begin @(negedge clk); if (pwmOut) hi++; end
    chk("R5 toggle mode duty", hi, 16);
    wr(A_CFG, 0);
    wr(A_STS, 32'h7);
  endtask

  task automatic testCapture();
    logic [31:0] v;
    wr(A_CNT, 32'h1234);
    wr(A_CFG, 32'h100);              // rising only
    @(negedge clk); capIn = 1'b1;
    repeat (4) @(posedge clk);
    rd(A_CAP, v); chk("R6 rising capture", v, 32'h1234);
    rd(A_STS, v); chk("R6 capture flag", v, 4);
    wr(A_STS, 32'h4);
    wr(A_CNT, 32'h5678);
    @(negedge clk); capIn = 1'b0;
    repeat (4) @(posedge clk);
    rd(A_CAP, v); chk("R6 falling ignored", v, 32'h1234);
    rd(A_STS, v); chk("R6 no flag on ignored edge", v, 0);
    wr(A_CFG, 32'h300);              // both edges
    wr(A_CNT, 32'h9ABC);
    @(negedge clk); capIn = 1'b1;
    repeat (4) @(posedge clk);
    rd(A_CAP, v); chk("R6 both edges", v, 32'h9ABC);
    wr(A_CFG, 0);
    wr(A_STS, 32'h7);
  endtask

  task automatic testAccessSize();
    logic [31:0] v;
    wr(A_RLD, 32'h1111_2222);
    wr(A_RLD, 32'hABCD_0000, 4'b1100);
    rd(A_RLD, v); chk("R10 high half write", v, 32'hABCD_2222);
    wr(A_RLD, 32'h0000_FFFF, 4'b0001);
    rd(A_RLD, v); chk("R10 byte write ignored", v, 32'hABCD_2222);
    wr(A_RLD, 32'h0000_3333, 4'b0011);
    rd(A_RLD, v); chk("R10 low half write", v, 32'hABCD_3333);
    rd(10'h3FC, v); chk("R10 unmapped reads zero", v, 0);
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testHoldAndPrescale();
    testOverflow();
    testCompareIrq();
    testPendingWrite();
    testPwm();
    testCapture();
    testAccessSize();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule